// File: doc/BRIEF.md
# Software Trace Stimulus Register Frontend

This block is the memory-mapped register face of a software trace source. Software writes a word to one of 32 stimulus ports. If that write passes every filter, the frontend hands the port number and the data word to a downstream FIFO as a single push. The filters are:

- a global master enable;
- a per-port enable mask;
- a four-bit privilege mask, where each bit guards a group of eight ports;
- the FIFO full flag.

A read of any stimulus port returns the FIFO's room flag in bit 0, so software can poll it before writing.

The enable, privilege and control registers are protected by a key lock. Only a privileged write of the key word to the lock-key register unlocks them. Any other value written there locks them again. Reads always work. Packet encoding, the FIFO itself and the serial trace output live elsewhere.

Top module: `trace_stim_front`

## Requirements
- R1: After reset the frontend is locked. The port-enable register (0xE00), the group privilege mask (0xE40) and the control register (0xE80) all read 0. The lock-status register (0xFB4) reads 3.
- R2: A privileged write of 0xC5ACCE55 to the lock-key register (0xFB0) unlocks, and lock status then reads 1. A privileged write of any other value locks again, and lock status reads 3. A user-mode write to 0xFB0 has no effect. In lock status, bit 0 is always 1, bit 1 is 1 while locked, and bit 2 is always 0.
- R3: While locked, writes to 0xE00, 0xE40 and 0xE80 are ignored and those registers still read back their old contents. Stimulus writes are not affected by the lock.
- R4: A write to the port-enable register takes effect only when control bit 0 (master enable) is already 1. The control register keeps only bit 0; its other bits read 0.
- R5: A write to stimulus port n (byte offset 4*n, n = 0..31) that passes every filter sets push_valid in the cycle after the write edge. In that cycle push_port equals n and push_data equals the written word.
- R6: No push happens when master enable is 0, or when bit n of the port-enable register is 0.
- R7: The privilege mask keeps 4 bits; bit k covers ports 8k..8k+7. When bit k is 1, user-mode writes to those ports are dropped without a push. Privileged writes always pass this filter.
- R8: No push happens when fifo_full is 1 in the cycle of the stimulus write.
- R9: A read of any stimulus port returns bit 0 = 1 when fifo_full is 0 and bit 0 = 0 when it is 1. All other bits read 0.
- R10: Offsets outside the map, including the lock-key register itself, read as 0. Writes to offsets outside the map change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| fifo_full | input | 1 | Downstream FIFO cannot take a push |
| push_valid | output | 1 | Push strobe to FIFO |
| push_port | output | 5 | Stimulus port of the push |
| push_data | output | 32 | Data word of the push |

## Verification
A scoreboard queue holds every push the bench expects, and any push without a queued entry is a failure. This catches a design that leaks a write through a disabled port, a privilege-guarded group, or a full FIFO. The group boundaries are probed directly: ports 15 and 16 lie on either side of a guarded group edge, so a design that decodes the group with the wrong bit would push on port 15 or drop port 16. The bench also tries to set the port enables before the master enable and while locked, and tries unlocking from user mode. A design that ignored either gate would read back a changed mask or an unlocked status.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STIM,
        RG_TEN,
        RG_PRIV,
        RG_CTRL,
        RG_LKEY,
        RG_LSTAT
    } region_e;

    localparam logic [11:0] OFS_TEN   = 12'hE00;
    localparam logic [11:0] OFS_PRIV  = 12'hE40;
    localparam logic [11:0] OFS_CTRL  = 12'hE80;
    localparam logic [11:0] OFS_LKEY  = 12'hFB0;
    localparam logic [11:0] OFS_LSTAT = 12'hFB4;

    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

    // bit0: lock present, bit1: writes blocked, bit2: no byte-wide lock access
    function automatic logic [2:0] lock_status(input logic locked);
        return {1'b0, locked, 1'b1};
    endfunction

endpackage

// File: rtl/tsf_decode.sv
module tsf_decode
    import tsf_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int AW    = 12,
    parameter int PW    = $clog2(NPORT)
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [PW-1:0] port
);
    localparam int STIM_SPAN = 4 * NPORT;

    logic [31:0] addr_wide;
    assign addr_wide = {{(32-AW){1'b0}}, addr};

    always_comb begin
        port   = addr[PW+1:2];
        region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr_wide < 32'(STIM_SPAN))       region = RG_STIM;
            else if (addr == AW'(OFS_TEN))        region = RG_TEN;
            else if (addr == AW'(OFS_PRIV))       region = RG_PRIV;
            else if (addr == AW'(OFS_CTRL))       region = RG_CTRL;
            else if (addr == AW'(OFS_LKEY))       region = RG_LKEY;
            else if (addr == AW'(OFS_LSTAT))      region = RG_LSTAT;
        end
    end
endmodule

// File: rtl/tsf_cfg_regs.sv
module tsf_cfg_regs
    import tsf_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NGRP  = 4,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  region_e          region,
    input  logic             priv,
    input  logic [DW-1:0]    wdata,
    output logic [NPORT-1:0] ter,
    output logic [NGRP-1:0]  tpr,
    output logic             master_en,
    output logic             locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ter       <= '0;
            tpr       <= '0;
            master_en <= 1'b0;
            locked    <= 1'b1;
        end else if (wr_en) begin
            case (region)
                RG_LKEY: if (priv) locked <= (wdata != DW'(UNLOCK_KEY));
                RG_TEN:  if (!locked && master_en) ter <= wdata[NPORT-1:0];
                RG_PRIV: if (!locked) tpr <= wdata[NGRP-1:0];
                RG_CTRL: if (!locked) master_en <= wdata[0];
                default: ;
            endcase
        end
    end

    // R3: protected registers hold while locked
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(ter) && $stable(tpr) && $stable(master_en)));

    // R4: port enables cannot change without master enable
    p_ten_master_r4: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> $stable(ter));

    // R2: user-mode key writes never move the lock
    p_user_key_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && region == RG_LKEY && !priv) |=> $stable(locked));
endmodule

// File: rtl/tsf_push_gate.sv
module tsf_push_gate #(
    parameter int NPORT = 32,
    parameter int GRP   = 8,
    parameter int NGRP  = 4,
    parameter int DW    = 32,
    parameter int PW    = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stim_wr,
    input  logic [PW-1:0]    port,
    input  logic [DW-1:0]    wdata,
    input  logic             priv,
    input  logic [NPORT-1:0] ter,
    input  logic [NGRP-1:0]  tpr,
    input  logic             master_en,
    input  logic             fifo_full,
    output logic             push_valid,
    output logic [PW-1:0]    push_port,
    output logic [DW-1:0]    push_data
);
    logic [NPORT-1:0] priv_only;
    logic             accept;

    for (genvar g = 0; g < NPORT; g++) begin : g_grp
        assign priv_only[g] = tpr[g / GRP];
    end

    assign accept = stim_wr && master_en && ter[port]
                    && (priv || !priv_only[port]) && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid <= 1'b0;
            push_port  <= '0;
            push_data  <= '0;
        end else begin
            push_valid <= accept;
            if (accept) begin
                push_port <= port;
                push_data <= wdata;
            end
        end
    end

    // R6: a push needs master enable and the port's enable bit
    p_push_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> ($past(master_en) && $past(ter[port])));

    // R8: never push into a full FIFO
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> !$past(fifo_full));

    // R7: user writes to a guarded group are dropped
    p_user_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (stim_wr && !priv && priv_only[port]) |=> !push_valid);

    // R5: the push carries the port that was written
    p_push_port_r5: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> (push_port == $past(port) && push_data == $past(wdata)));
endmodule

// File: rtl/tsf_read_mux.sv
module tsf_read_mux
    import tsf_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NGRP  = 4,
    parameter int DW    = 32
) (
    input  logic             sel,
    input  region_e          region,
    input  logic [NPORT-1:0] ter,
    input  logic [NGRP-1:0]  tpr,
    input  logic             master_en,
    input  logic             locked,
    input  logic             fifo_full,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (region)
                RG_STIM:  rdata = DW'(!fifo_full);
                RG_TEN:   rdata = DW'(ter);
                RG_PRIV:  rdata = DW'(tpr);
                RG_CTRL:  rdata = DW'(master_en);
                RG_LSTAT: rdata = DW'(lock_status(locked));
                default:  rdata = '0;
            endcase
        end
    end

    // R9: stimulus reads carry only the room flag
    always_comb begin
        if (sel && region == RG_STIM) begin
            p_stim_read_r9: assert (rdata[DW-1:1] == '0);
        end
    end
endmodule

// File: rtl/trace_stim_front.sv
module trace_stim_front
    import tsf_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int GRP   = 8,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic                     bus_priv,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic                     fifo_full,
    output logic                     push_valid,
    output logic [$clog2(NPORT)-1:0] push_port,
    output logic [DW-1:0]            push_data
);
    localparam int NGRP = NPORT / GRP;
    localparam int PW   = $clog2(NPORT);

    region_e          region;
    logic [PW-1:0]    port;
    logic [NPORT-1:0] ter;
    logic [NGRP-1:0]  tpr;
    logic             master_en;
    logic             locked;
    logic             wr_en;

    assign wr_en = bus_sel && bus_wr;

    tsf_decode #(.NPORT(NPORT), .AW(AW), .PW(PW)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .port   (port)
    );

    tsf_cfg_regs #(.NPORT(NPORT), .NGRP(NGRP), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .region    (region),
        .priv      (bus_priv),
        .wdata     (bus_wdata),
        .ter       (ter),
        .tpr       (tpr),
        .master_en (master_en),
        .locked    (locked)
    );

    tsf_push_gate #(.NPORT(NPORT), .GRP(GRP), .NGRP(NGRP), .DW(DW), .PW(PW)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .stim_wr    (wr_en && region == RG_STIM),
        .port       (port),
        .wdata      (bus_wdata),
        .priv       (bus_priv),
        .ter        (ter),
        .tpr        (tpr),
        .master_en  (master_en),
        .fifo_full  (fifo_full),
        .push_valid (push_valid),
        .push_port  (push_port),
        .push_data  (push_data)
    );

    tsf_read_mux #(.NPORT(NPORT), .NGRP(NGRP), .DW(DW)) u_rd (
        .sel       (bus_sel && !bus_wr),
        .region    (region),
        .ter       (ter),
        .tpr       (tpr),
        .master_en (master_en),
        .locked    (locked),
        .fifo_full (fifo_full),
        .rdata     (bus_rdata)
    );

    // R10: writes outside the map leave all state untouched
    p_undef_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && region == RG_NONE) |=> ($stable(ter) && $stable(tpr)
                                          && $stable(master_en) && $stable(locked)));
endmodule

// File: tb/trace_stim_front_test.sv
module trace_stim_front_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fifo_full = 1'b0;
    logic        push_valid;
    logic [4:0]  push_port;
    logic [31:0] push_data;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [36:0] expq[$];

    always #10 clk = ~clk;   // 50 MHz

    trace_stim_front uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_full(fifo_full), .push_valid(push_valid), .push_port(push_port),
        .push_data(push_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = 1'b1;
        #2;
        check(bus_rdata == exp, tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic stim(input int n, input logic [31:0] d, input logic p, input bit exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(4 * n); bus_wdata = d; bus_priv = p;
        if (exp) expq.push_back({5'(n), d});
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check(push_valid == exp, tag, push_valid, exp);
    endtask

    // monitor: compare every produced push with the scoreboard
    always @(negedge clk) begin
        if (!rst && push_valid) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R5 unexpected push actual=%0h expected=none", {push_port, push_data});
            end else begin
                logic [36:0] e;
                e = expq.pop_front();
                if ({push_port, push_data} != e) begin
                    bad++;
                    $display("FAIL R5 push content actual=%0h expected=%0h", {push_port, push_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_check(12'hFB4, 32'h3, "R1 lock status after reset");
        read_check(12'hE00, 32'h0, "R1 port enables after reset");
        read_check(12'hE40, 32'h0, "R1 privilege mask after reset");
        read_check(12'hE80, 32'h0, "R1 control after reset");

        // R3 locked writes ignored
        bus_write(12'hE80, 32'h1, 1'b1);
        read_check(12'hE80, 32'h0, "R3 control write while locked");
        read_check(12'h000, 32'h1, "R9 stim read not full");

        // R2 key handling
        bus_write(12'hFB0, 32'hC5AC_CE55, 1'b0);
        read_check(12'hFB4, 32'h3, "R2 user key write ignored");
        bus_write(12'hFB0, 32'hC5AC_CE55, 1'b1);
        read_check(12'hFB4, 32'h1, "R2 privileged key unlocks");

        // R4 port enable needs master enable
        bus_write(12'hE00, 32'hFFFF_FFFF, 1'b1);
        read_check(12'hE00, 32'h0, "R4 enable write without master");
        bus_write(12'hE80, 32'hFFFF_FFFF, 1'b1);
        read_check(12'hE80, 32'h1, "R4 control keeps bit0 only");
        stim(3, 32'h1111_0000, 1'b1, 1'b0, "R6 port disabled");
        bus_write(12'hE00, 32'h8001_8109, 1'b1);
        read_check(12'hE00, 32'h8001_8109, "R4 enable write with master");

        // R5 pushes
        stim(3, 32'h0000_00A5, 1'b0, 1'b1, "R5 user push port 3");
        stim(31, 32'hDEAD_BEEF, 1'b1, 1'b1, "R5 push port 31");
        stim(8, 32'h1234_5678, 1'b0, 1'b1, "R5 push port 8");
        stim(2, 32'h2222_2222, 1'b1, 1'b0, "R6 port 2 not enabled");

        // R7 privilege groups (bits 1 and 3 set)
        bus_write(12'hE40, 32'h0000_00FA, 1'b1);
        read_check(12'hE40, 32'hA, "R7 mask keeps 4 bits");
        stim(8, 32'h8888_0001, 1'b0, 1'b0, "R7 user blocked port 8");
        stim(15, 32'h1515_0001, 1'b0, 1'b0, "R7 user blocked port 15");
        stim(16, 32'h1616_0001, 1'b0, 1'b1, "R7 user allowed port 16");
        stim(8, 32'h8888_0002, 1'b1, 1'b1, "R7 privileged port 8");
        stim(31, 32'h3131_0001, 1'b0, 1'b0, "R7 user blocked port 31");
        stim(3, 32'h0303_0001, 1'b0, 1'b1, "R7 user allowed port 3");

        // R8 / R9 full FIFO
        fifo_full = 1'b1;
        read_check(12'h014, 32'h0, "R9 stim read full");
        stim(0, 32'h0F0F_0F0F, 1'b1, 1'b0, "R8 no push when full");
        fifo_full = 1'b0;
        stim(0, 32'hF0F0_F0F0, 1'b1, 1'b1, "R8 push after full clears");

        // R10 undefined offsets
        bus_write(12'h100, 32'hFFFF_FFFF, 1'b1);
        read_check(12'h100, 32'h0, "R10 undefined read");
        read_check(12'hFB0, 32'h0, "R10 key register reads zero");
        read_check(12'hE00, 32'h8001_8109, "R10 enables unchanged");

        // R2 / R3 relock
        bus_write(12'hFB0, 32'h0000_1234, 1'b1);
        read_check(12'hFB4, 32'h3, "R2 other value relocks");
        bus_write(12'hE00, 32'h0, 1'b1);
        read_check(12'hE00, 32'h8001_8109, "R3 enable write while locked");
        stim(3, 32'h0303_0002, 1'b1, 1'b1, "R3 stimulus works while locked");

        // R6 master enable off
        bus_write(12'hFB0, 32'hC5AC_CE55, 1'b1);
        bus_write(12'hE80, 32'h0, 1'b1);
        stim(3, 32'h0303_0003, 1'b1, 1'b0, "R6 master disabled");

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R5 all expected pushes seen", expq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule